// File: doc/BRIEF.md
# Accumulator Operand Fetch Unit

This block executes one decoded accumulator instruction at a time. Each instruction carries an operation, an addressing mode, a 16-bit address-or-immediate field and a register selector. The unit works out where the operand lives and fetches it through its own address and data holding registers, which face a single-port word memory. It then updates the accumulator, or it stores the accumulator to a register or to memory, and it raises a one-cycle completion pulse.

A controller finite-state machine drives the whole sequence. Depending on the mode, it issues zero, one or two memory reads per operand. In memory-indirect mode it chains two reads: the first read fetches a pointer word, and that word becomes the address of the second read. The states are:
- `ST_IDLE`: waiting for an instruction.
- `ST_RD_PTR`, then `ST_WAIT_PTR`: pointer read and capture.
- `ST_RD_OPD`, then `ST_WAIT_OPD`: operand read and capture.
- `ST_EXEC`: accumulator update or register store.
- `ST_WR_ARM`, then `ST_WR_GO`: memory store setup and strobe.
- `ST_FINISH`: completion.

The transitions are:
- `ST_IDLE` goes to `ST_RD_PTR` for indirect mode.
- `ST_IDLE` goes to `ST_RD_OPD` for the other memory modes.
- `ST_IDLE` goes to `ST_WR_ARM` for a store in a one-read mode.
- `ST_IDLE` goes to `ST_EXEC` for the immediate and register modes.
- `ST_WAIT_PTR` goes to `ST_WR_ARM` for a store and to `ST_RD_OPD` for anything else.
- `ST_RD_OPD` goes to `ST_WAIT_OPD`, which goes to `ST_EXEC`.
- `ST_EXEC` goes to `ST_FINISH`.
- `ST_WR_ARM` goes to `ST_WR_GO`, which goes to `ST_FINISH`.
- `ST_FINISH` goes back to `ST_IDLE`.

Top module: `acc_operand_unit`

## Requirements
- R1: After reset the accumulator and all 8 registers read 0, and `busy`, `done`, `div_err`, `mem_rd` and `mem_wr` are low.
- R2: Immediate mode (code 0) uses the field as the operand. Register mode (code 3) uses the register picked by `instr_reg`. Neither mode touches memory, and `done` rises 2 cycles after the accepting edge.
- R3: Direct mode (code 1) reads memory once, at the field address, and `done` follows 4 cycles after acceptance.
- R4: Memory-indirect mode (code 2) first reads the word at the field address. It then reads the operand from the address held in that word: two reads in total, with `done` 6 cycles after acceptance.
- R5: Register-indirect mode (code 4) reads the operand at the address held in the selected register. Displacement mode (code 5) reads at the field plus the selected register, modulo 2^16. Each mode makes one read.
- R6: A read strobe `mem_rd` lasts one cycle and presents the address on `mem_addr`. The memory returns the word on `mem_rdata` in the following cycle. `mem_rd` and `mem_wr` are never high together.
- R7: The operation codes are LOAD=0, ADD=1, SUB=2, MPY=3 and DIV=4. ADD, SUB and MPY keep the low 16 bits of the result. DIV is unsigned and truncates.
- R8: DIV by zero leaves the accumulator unchanged and sets `div_err`. The flag rises together with `done` and clears when the next instruction is accepted.
- R9: STOR (code 5) behaves as follows, and it never changes the accumulator:
  - In register mode it copies the accumulator into the selected register.
  - In the direct, indirect, register-indirect and displacement modes it writes the accumulator to the effective address with a one-cycle `mem_wr`. No operand read takes place; indirect mode reads only the pointer.
  - In immediate mode it does nothing.
- R10: `busy` stays high from the accepting edge through the single-cycle `done` pulse. An `instr_valid` that arrives while `busy` is high is ignored. The accumulator does not change while idle.
- R11: Operation codes 6 and 7 complete without changing the accumulator, though they still fetch their operand. Mode codes 6 and 7 behave as immediate mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction present; taken only when idle |
| instr_op | input | 3 | Operation code |
| instr_mode | input | 3 | Addressing mode code |
| instr_field | input | 16 | Address, immediate or displacement base |
| instr_reg | input | 3 | Register selector |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| div_err | output | 1 | Last instruction divided by zero |
| acc_out | output | 16 | Accumulator value |
| mem_addr | output | 16 | Memory address register |
| mem_wdata | output | 16 | Memory data register, write side |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_rdata | input | 16 | Read word, valid the cycle after `mem_rd` |

## Verification
The hardest case to reach is the two-read pointer chain in a store. The indirect-mode write must take its address from a pointer word fetched from memory, and it must never read an operand. A bare port test cannot reach this without registers and memory already holding known pointers. The stimulus therefore first builds state through the unit's own instructions: an immediate load followed by a register store sets up the base register. It then runs the indirect store and reads the target location back with a direct load. Separately, a second `instr_valid` is injected in the middle of a direct load to show that the busy window rejects it.

// File: rtl/acc_pkg.sv
package acc_pkg;

    typedef enum logic [2:0] {
        OP_LOAD = 3'd0,
        OP_ADD  = 3'd1,
        OP_SUB  = 3'd2,
        OP_MPY  = 3'd3,
        OP_DIV  = 3'd4,
        OP_STOR = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } acc_op_e;

    typedef enum logic [2:0] {
        AM_IMM  = 3'd0,
        AM_DIR  = 3'd1,
        AM_IND  = 3'd2,
        AM_REG  = 3'd3,
        AM_RIND = 3'd4,
        AM_DISP = 3'd5,
        AM_RSV6 = 3'd6,
        AM_RSV7 = 3'd7
    } addr_mode_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_PTR,
        ST_WAIT_PTR,
        ST_RD_OPD,
        ST_WAIT_OPD,
        ST_EXEC,
        ST_WR_ARM,
        ST_WR_GO,
        ST_FINISH
    } fsm_state_e;

endpackage

// File: rtl/acc_regfile.sv
module acc_regfile #(
    parameter int WORD_W = 16,
    parameter int REG_N  = 8,
    localparam int SEL_W = $clog2(REG_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [WORD_W-1:0] rd_data
);

    logic [WORD_W-1:0] regs [REG_N];

    for (genvar i = 0; i < REG_N; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[i] <= '0;
            end else if (wr_en && (wr_sel == SEL_W'(i))) begin
                regs[i] <= wr_data;
            end
        end
    end

    assign rd_data = regs[rd_sel];

endmodule

// File: rtl/acc_ea_unit.sv
module acc_ea_unit
    import acc_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  addr_mode_e        mode,
    input  logic [WORD_W-1:0] field,
    input  logic [WORD_W-1:0] reg_val,
    output logic [WORD_W-1:0] ea,
    output logic [WORD_W-1:0] direct_opnd,
    output logic              ptr_fetch,
    output logic              mem_operand
);

    // Classify the mode: where the operand comes from and how many reads.
    always_comb begin
        ea          = field;
        direct_opnd = field;
        ptr_fetch   = 1'b0;
        mem_operand = 1'b0;
        unique case (mode)
            AM_DIR: begin
                mem_operand = 1'b1;
            end
            AM_IND: begin
                ptr_fetch   = 1'b1;
                mem_operand = 1'b1;
            end
            AM_REG: begin
                direct_opnd = reg_val;
            end
            AM_RIND: begin
                ea          = reg_val;
                mem_operand = 1'b1;
            end
            AM_DISP: begin
                ea          = field + reg_val;
                mem_operand = 1'b1;
            end
            default: begin
                // immediate and reserved codes: field is the operand
            end
        endcase
    end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  acc_op_e           op,
    input  logic [WORD_W-1:0] acc,
    input  logic [WORD_W-1:0] opnd,
    output logic [WORD_W-1:0] result,
    output logic              acc_we,
    output logic              div_zero
);

    always_comb begin
        result   = acc;
        acc_we   = 1'b0;
        div_zero = 1'b0;
        unique case (op)
            OP_LOAD: begin
                result = opnd;
                acc_we = 1'b1;
            end
            OP_ADD: begin
                result = acc + opnd;
                acc_we = 1'b1;
            end
            OP_SUB: begin
                result = acc - opnd;
                acc_we = 1'b1;
            end
            OP_MPY: begin
                result = acc * opnd;
                acc_we = 1'b1;
            end
            OP_DIV: begin
                if (opnd == '0) begin
                    div_zero = 1'b1;
                end else begin
                    result = acc / opnd;
                    acc_we = 1'b1;
                end
            end
            default: begin
                // store and reserved codes leave the accumulator alone
            end
        endcase
    end

endmodule

// File: rtl/acc_operand_unit.sv
module acc_operand_unit
    import acc_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int REG_N  = 8,
    localparam int SEL_W = $clog2(REG_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [2:0]        instr_op,
    input  logic [2:0]        instr_mode,
    input  logic [WORD_W-1:0] instr_field,
    input  logic [SEL_W-1:0]  instr_reg,
    output logic              busy,
    output logic              done,
    output logic              div_err,
    output logic [WORD_W-1:0] acc_out,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              mem_rd,
    output logic              mem_wr,
    input  logic [WORD_W-1:0] mem_rdata
);

    fsm_state_e        state_q, state_d;
    acc_op_e           op_q;
    addr_mode_e        mode_q;
    logic [SEL_W-1:0]  sel_q;
    logic [WORD_W-1:0] opnd_q, mar_q, mdr_q, acc_q;
    logic              div_err_q;

    logic              accept;
    logic [WORD_W-1:0] reg_val, ea, direct_opnd, alu_res;
    logic              ptr_fetch, mem_operand, alu_we, div_zero, rf_we;
    acc_op_e           in_op;
    addr_mode_e        in_mode;

    assign in_op   = acc_op_e'(instr_op);
    assign in_mode = addr_mode_e'(instr_mode);
    assign accept  = (state_q == ST_IDLE) && instr_valid;
    assign rf_we   = (state_q == ST_EXEC) && (op_q == OP_STOR) && (mode_q == AM_REG);

    acc_regfile #(.WORD_W(WORD_W), .REG_N(REG_N)) u_regfile (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (rf_we),
        .wr_sel  (sel_q),
        .wr_data (acc_q),
        .rd_sel  (instr_reg),
        .rd_data (reg_val)
    );

    acc_ea_unit #(.WORD_W(WORD_W)) u_ea (
        .mode        (in_mode),
        .field       (instr_field),
        .reg_val     (reg_val),
        .ea          (ea),
        .direct_opnd (direct_opnd),
        .ptr_fetch   (ptr_fetch),
        .mem_operand (mem_operand)
    );

    acc_alu #(.WORD_W(WORD_W)) u_alu (
        .op       (op_q),
        .acc      (acc_q),
        .opnd     (opnd_q),
        .result   (alu_res),
        .acc_we   (alu_we),
        .div_zero (div_zero)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (instr_valid) begin
                    if (ptr_fetch) begin
                        state_d = ST_RD_PTR;
                    end else if (mem_operand) begin
                        state_d = (in_op == OP_STOR) ? ST_WR_ARM : ST_RD_OPD;
                    end else begin
                        state_d = ST_EXEC;
                    end
                end
            end
            ST_RD_PTR:   state_d = ST_WAIT_PTR;
            ST_WAIT_PTR: state_d = (op_q == OP_STOR) ? ST_WR_ARM : ST_RD_OPD;
            ST_RD_OPD:   state_d = ST_WAIT_OPD;
            ST_WAIT_OPD: state_d = ST_EXEC;
            ST_EXEC:     state_d = ST_FINISH;
            ST_WR_ARM:   state_d = ST_WR_GO;
            ST_WR_GO:    state_d = ST_FINISH;
            ST_FINISH:   state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        busy      = (state_q != ST_IDLE);
        done      = (state_q == ST_FINISH);
        mem_rd    = (state_q == ST_RD_PTR) || (state_q == ST_RD_OPD);
        mem_wr    = (state_q == ST_WR_GO);
        mem_addr  = mar_q;
        mem_wdata = mdr_q;
        acc_out   = acc_q;
        div_err   = div_err_q;
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q      <= OP_LOAD;
            mode_q    <= AM_IMM;
            sel_q     <= '0;
            opnd_q    <= '0;
            mar_q     <= '0;
            mdr_q     <= '0;
            acc_q     <= '0;
            div_err_q <= 1'b0;
        end else begin
            if (accept) begin
                op_q      <= in_op;
                mode_q    <= in_mode;
                sel_q     <= instr_reg;
                opnd_q    <= direct_opnd;
                mar_q     <= ea;
                div_err_q <= 1'b0;
            end
            if (state_q == ST_WAIT_PTR) begin
                mdr_q <= mem_rdata;
                mar_q <= mem_rdata;
            end
            if (state_q == ST_WAIT_OPD) begin
                mdr_q  <= mem_rdata;
                opnd_q <= mem_rdata;
            end
            if (state_q == ST_EXEC) begin
                if (alu_we) begin
                    acc_q <= alu_res;
                end
                if (div_zero) begin
                    div_err_q <= 1'b1;
                end
            end
            if (state_q == ST_WR_ARM) begin
                mdr_q <= acc_q;
            end
        end
    end

endmodule

// File: rtl/acc_operand_unit_chk.sv
module acc_operand_unit_chk #(
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              div_err,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [WORD_W-1:0] mem_wdata,
    input logic [WORD_W-1:0] acc_out
);

    a_r6_rd_wr_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    a_r6_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);

    a_r9_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> !mem_wr);

    a_r9_wr_data_is_acc: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (mem_wdata == acc_out));

    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r10_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    a_r10_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    a_r10_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_rd && !mem_wr));

    a_r10_acc_held_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(acc_out));

    a_r8_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(div_err) |-> done);

endmodule

bind acc_operand_unit acc_operand_unit_chk #(.WORD_W(WORD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .div_err   (div_err),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_wdata (mem_wdata),
    .acc_out   (acc_out)
);

// File: tb/test_acc_operand_unit.sv
`timescale 1ns/1ps
module test_acc_operand_unit;
    import acc_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        instr_valid;
    logic [2:0]  instr_op, instr_mode, instr_reg;
    logic [15:0] instr_field;
    logic        busy, done, div_err, mem_rd, mem_wr;
    logic [15:0] acc_out, mem_addr, mem_wdata, mem_rdata;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    logic [15:0] mem [256];
    logic [15:0] rd_addr_log [2];
    logic [15:0] wr_addr_log;

    always #2 clk = ~clk;

    acc_operand_unit i_acc_operand_unit (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_op(instr_op),
        .instr_mode(instr_mode), .instr_field(instr_field), .instr_reg(instr_reg),
        .busy(busy), .done(done), .div_err(div_err), .acc_out(acc_out),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_rdata(mem_rdata)
    );

    // Memory model: word returned the cycle after the read strobe
    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
    end

    typedef struct packed {
        logic [7:0]  req;
        logic [2:0]  op;
        logic [2:0]  md;
        logic [15:0] fld;
        logic [2:0]  sel;
        logic [15:0] acc;
        logic [3:0]  rd;
        logic [3:0]  wr;
        logic [3:0]  cyc;
    } vec_t;

    localparam int NV = 29;
    // req, op, mode, field, sel, expected acc, reads, writes, cycles to done
    localparam vec_t VEC [NV] = '{
        '{8'd1,  3'd0, 3'd3, 16'd0,     3'd5, 16'd0,     4'd0, 4'd0, 4'd2}, // R1 regs zero
        '{8'd2,  3'd0, 3'd0, 16'd50,    3'd0, 16'd50,    4'd0, 4'd0, 4'd2}, // R2
        '{8'd9,  3'd5, 3'd3, 16'd0,     3'd2, 16'd50,    4'd0, 4'd0, 4'd2}, // R9 reg C
        '{8'd5,  3'd0, 3'd4, 16'd0,     3'd2, 16'd3,     4'd1, 4'd0, 4'd4}, // R5
        '{8'd3,  3'd1, 3'd1, 16'd3,     3'd0, 16'd46,    4'd1, 4'd0, 4'd4}, // R3
        '{8'd4,  3'd2, 3'd2, 16'd0,     3'd0, 16'd36,    4'd2, 4'd0, 4'd6}, // R4
        '{8'd5,  3'd3, 3'd5, 16'd50,    3'd2, 16'd180,   4'd1, 4'd0, 4'd4}, // R5
        '{8'd7,  3'd4, 3'd0, 16'd9,     3'd0, 16'd20,    4'd0, 4'd0, 4'd2}, // R7
        '{8'd9,  3'd5, 3'd3, 16'd0,     3'd6, 16'd20,    4'd0, 4'd0, 4'd2}, // R9 reg Y
        '{8'd2,  3'd0, 3'd0, 16'd0,     3'd0, 16'd0,     4'd0, 4'd0, 4'd2}, // R2
        '{8'd2,  3'd0, 3'd3, 16'd0,     3'd6, 16'd20,    4'd0, 4'd0, 4'd2}, // R2 Y readback
        '{8'd9,  3'd5, 3'd1, 16'd200,   3'd0, 16'd20,    4'd0, 4'd1, 4'd3}, // R9
        '{8'd2,  3'd0, 3'd0, 16'd7,     3'd0, 16'd7,     4'd0, 4'd0, 4'd2}, // R2
        '{8'd3,  3'd0, 3'd1, 16'd200,   3'd0, 16'd20,    4'd1, 4'd0, 4'd4}, // R3
        '{8'd9,  3'd5, 3'd2, 16'd0,     3'd0, 16'd20,    4'd1, 4'd1, 4'd5}, // R9 indirect
        '{8'd3,  3'd0, 3'd1, 16'd52,    3'd0, 16'd20,    4'd1, 4'd0, 4'd4}, // R3
        '{8'd2,  3'd0, 3'd0, 16'd5,     3'd0, 16'd5,     4'd0, 4'd0, 4'd2}, // R2
        '{8'd7,  3'd2, 3'd0, 16'd7,     3'd0, 16'hFFFE,  4'd0, 4'd0, 4'd2}, // R7
        '{8'd2,  3'd0, 3'd0, 16'h1000,  3'd0, 16'h1000,  4'd0, 4'd0, 4'd2}, // R2
        '{8'd7,  3'd3, 3'd0, 16'h0020,  3'd0, 16'h0000,  4'd0, 4'd0, 4'd2}, // R7
        '{8'd2,  3'd0, 3'd0, 16'hFFF0,  3'd0, 16'hFFF0,  4'd0, 4'd0, 4'd2}, // R2
        '{8'd7,  3'd1, 3'd0, 16'h0020,  3'd0, 16'h0010,  4'd0, 4'd0, 4'd2}, // R7
        '{8'd2,  3'd0, 3'd0, 16'd100,   3'd0, 16'd100,   4'd0, 4'd0, 4'd2}, // R2
        '{8'd7,  3'd4, 3'd0, 16'd7,     3'd0, 16'd14,    4'd0, 4'd0, 4'd2}, // R7
        '{8'd11, 3'd7, 3'd0, 16'd123,   3'd0, 16'd14,    4'd0, 4'd0, 4'd2}, // R11
        '{8'd9,  3'd5, 3'd0, 16'd9,     3'd0, 16'd14,    4'd0, 4'd0, 4'd2}, // R9 imm store
        '{8'd5,  3'd0, 3'd5, 16'hFFD2,  3'd2, 16'd77,    4'd1, 4'd0, 4'd4}, // R5 wrap
        '{8'd11, 3'd0, 3'd7, 16'd33,    3'd0, 16'd33,    4'd0, 4'd0, 4'd2}, // R11
        '{8'd11, 3'd6, 3'd1, 16'd3,     3'd0, 16'd33,    4'd1, 4'd0, 4'd4}  // R11
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] op, input logic [2:0] md,
                         input logic [15:0] fld, input logic [2:0] sel,
                         output int cyc, output int rd, output int wr, output int gaps);
        @(negedge clk);
        instr_valid = 1'b1;
        instr_op = op; instr_mode = md; instr_field = fld; instr_reg = sel;
        cyc = 0; rd = 0; wr = 0; gaps = 0;
        do begin
            @(negedge clk);
            instr_valid = 1'b0;
            cyc++;
            if (mem_rd) begin
                if (rd < 2) rd_addr_log[rd] = mem_addr;
                rd++;
            end
            if (mem_wr) begin
                wr_addr_log = mem_addr;
                wr++;
            end
            if (!busy) gaps++;
        end while (!done && cyc < 40);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL R10 watchdog actual=hung expected=complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int cyc, rd, wr, gaps;
        for (int i = 0; i < 256; i++) mem[i] = '0;
        mem[0] = 16'd52; mem[3] = 16'd43; mem[4] = 16'd77;
        mem[50] = 16'd3; mem[52] = 16'd10; mem[100] = 16'd5;
        rst_n = 1'b0; instr_valid = 1'b0;
        instr_op = '0; instr_mode = '0; instr_field = '0; instr_reg = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", "acc", acc_out, 0);
        check("R1", "busy", busy, 0);
        check("R1", "done", done, 0);
        check("R1", "div_err", div_err, 0);
        check("R1", "strobes", {mem_rd, mem_wr}, 0);

        for (int i = 0; i < NV; i++) begin
            string r;
            r = $sformatf("R%0d", VEC[i].req);
            issue(VEC[i].op, VEC[i].md, VEC[i].fld, VEC[i].sel, cyc, rd, wr, gaps);
            check(r, $sformatf("row%0d acc", i), acc_out, VEC[i].acc);
            check(r, $sformatf("row%0d reads", i), rd, VEC[i].rd);
            check(r, $sformatf("row%0d writes", i), wr, VEC[i].wr);
            check(r, $sformatf("row%0d cycles", i), cyc, VEC[i].cyc);
            check("R10", $sformatf("row%0d busy gaps", i), gaps, 0);
        end

        // R6 pointer chain addresses: mem[0]=52, mem[52]=20
        issue(3'd0, 3'd2, 16'd0, 3'd0, cyc, rd, wr, gaps);
        check("R6", "first read addr", rd_addr_log[0], 16'd0);
        check("R6", "second read addr", rd_addr_log[1], 16'd52);
        check("R4", "indirect acc", acc_out, 16'd20);

        // R9 register-indirect store writes at reg C (50)
        issue(3'd5, 3'd4, 16'd0, 3'd2, cyc, rd, wr, gaps);
        check("R9", "store addr", wr_addr_log, 16'd50);
        check("R9", "store reads", rd, 0);
        check("R9", "mem[50]", mem[50], 16'd20);

        // R8 division by zero
        issue(3'd0, 3'd0, 16'd40, 3'd0, cyc, rd, wr, gaps);
        issue(3'd4, 3'd0, 16'd0, 3'd0, cyc, rd, wr, gaps);
        check("R8", "acc kept", acc_out, 16'd40);
        check("R8", "err at done", div_err, 1);
        issue(3'd0, 3'd0, 16'd1, 3'd0, cyc, rd, wr, gaps);
        check("R8", "err cleared", div_err, 0);

        // R10 valid during busy is ignored
        @(negedge clk);
        instr_valid = 1'b1; instr_op = 3'd0; instr_mode = 3'd1;
        instr_field = 16'd3; instr_reg = 3'd0;
        @(negedge clk);
        instr_valid = 1'b0;
        @(negedge clk);
        instr_valid = 1'b1; instr_op = 3'd0; instr_mode = 3'd0; instr_field = 16'd99;
        @(negedge clk);
        instr_valid = 1'b0;
        while (!done) @(negedge clk);
        check("R10", "acc after direct", acc_out, 16'd43);
        @(negedge clk);
        check("R10", "done single", done, 0);
        begin
            int extra = 0;
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                if (done || busy) extra++;
            end
            check("R10", "no second instr", extra, 0);
        end
        check("R10", "acc held", acc_out, 16'd43);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule